// File: doc/BRIEF.md
# LCD Status Interrupt Controller

This block keeps the three registers that govern the LCD status interrupt: a control register, a status register and a line-compare register. The video mode and the current line number come in from the pixel pipeline and are not produced here. The block watches four conditions: horizontal blank, vertical blank, sprite-table search, and the current line equalling the compare value. Each condition can be enabled on its own. The enabled conditions are held in a four-bit source latch. A single-cycle request pulse goes to the interrupt-flag logic only when that latch goes from all-zero to nonzero, so several overlapping sources produce one request and not several.

A processor writes and reads the registers through a strobe interface that selects one of four slots with a two-bit selector. Writes to the status or compare register take effect on the interrupt logic in the same cycle. A status write can raise a request at once. A compare write can also raise one at once, because the match is computed against the value being written. Read data is registered and holds between reads. The block also drives the display-enable bit from the control register, and emits a one-cycle pulse when the window-enable bit is switched on.

Top module: `lcdstat_irq_ctrl`

## Requirements
- R1: After synchronous reset, `rd_data`, `irq_pulse`, `disp_en` and `win_rst` are 0, and all three stored registers are 0.
- R2: Register slots are selected by `reg_sel`: 0 = control, 1 = status, 2 = line, 3 = compare. A status write stores only `wr_data[6:3]` as enables: bit 3 = hblank, bit 4 = vblank, bit 5 = search, bit 6 = coincidence. A status read returns {1, enables[3:0], coincidence flag, `mode_in`}. The coincidence flag is set when the display is on and `line_in` equals the stored compare value.
- R3: A line read returns `line_in` when the display is on and 0x00 when it is off.
- R4: A control write stores all 8 bits. `disp_en` follows stored bit 7 from the next cycle. `win_rst` pulses for one cycle when a write sets bit 5 while the stored bit 5 is 0.
- R5: A compare write stores the value, and the match for that cycle uses the written value. Rewriting the value that is already stored raises no request.
- R6: `irq_pulse` rises in the cycle after the edge where the source latch goes from all-zero to nonzero. While the latch stays nonzero, no further pulse occurs.
- R7: When `mode_in` differs from its value at the previous edge, the three mode bits of the latch are recomputed from the enables. Mode encodings are 0 = hblank, 1 = vblank, 2 = search, 3 = transfer.
- R8: A status write first clears the latch bits whose new enable is 0. If the new hblank enable is set in mode 0, or the new vblank enable is set in mode 1, the write then sets that latch bit, and it requests an interrupt if the masked latch was all-zero.
- R9: A status write that enables search while in mode 2 requests an interrupt if the masked latch was all-zero, but leaves the search bit of the latch clear.
- R10: While `disp_en` is 0, the latch is held at zero and no request is raised.
- R11: The coincidence bit of the latch is 1 exactly while its enable is set and the line matches. A later re-match can therefore raise a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_sel | input | 2 | Register slot select |
| wr_data | input | 8 | Write data |
| mode_in | input | 2 | Current video mode |
| line_in | input | LINE_W | Current line number |
| rd_data | output | 8 | Registered read data |
| irq_pulse | output | 1 | One-cycle status interrupt request |
| disp_en | output | 1 | Display enable (control bit 7) |
| win_rst | output | 1 | One-cycle window line counter reset |

## Verification
Two functions can act in the same cycle and contend for the source latch. One is the mode-change recompute. The other is the immediate evaluation caused by a status or compare write. The random phase changes the mode and issues status and compare writes in the same cycles, with lines drawn from a narrow range so that matches are frequent. A bench reference model predicts every request pulse and every read result for each cycle. Directed sequences cover search-enable writes that are not latched, followed by a coincidence that must still fire.

// File: rtl/lcdstat_pkg.sv
package lcdstat_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned NSRC  = 4;
  localparam int unsigned NMODE_SRC = 3;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_LINE = 2'd2,
    SEL_CMP  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    VM_HBLANK = 2'd0,
    VM_VBLANK = 2'd1,
    VM_SEARCH = 2'd2,
    VM_XFER   = 2'd3
  } vmode_e;

  localparam int unsigned CTRL_DISP_BIT = 7;
  localparam int unsigned CTRL_WIN_BIT  = 5;
  localparam int unsigned STAT_EN_LSB   = 3;
  localparam int unsigned SRC_COIN      = 3;
endpackage

// File: rtl/lcdstat_regs.sv
module lcdstat_regs
  import lcdstat_pkg::*;
#(
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [1:0]        mode_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [NSRC-1:0]   en_q,
  output logic [LINE_W-1:0] cmp_q,
  output logic [LINE_W-1:0] cmp_eff,
  output logic              stat_wr,
  output logic [NSRC-1:0]   en_new,
  output logic [REG_W-1:0]  rd_data,
  output logic              win_rst
);
  logic ctrl_wr, cmp_wr, coin_rd;
  logic [REG_W-1:0] rd_mux;

  assign ctrl_wr = wr_en && (sel == SEL_CTRL);
  assign stat_wr = wr_en && (sel == SEL_STAT);
  assign cmp_wr  = wr_en && (sel == SEL_CMP);
  assign en_new  = wr_data[STAT_EN_LSB +: NSRC];
  assign cmp_eff = cmp_wr ? wr_data[LINE_W-1:0] : cmp_q;
  assign coin_rd = ctrl_q[CTRL_DISP_BIT] && (line_in == cmp_q);

  always_comb begin
    unique case (sel)
      SEL_CTRL: rd_mux = ctrl_q;
      SEL_STAT: rd_mux = {1'b1, en_q, coin_rd, mode_in};
      SEL_LINE: rd_mux = ctrl_q[CTRL_DISP_BIT] ? REG_W'(line_in) : '0;
      default:  rd_mux = REG_W'(cmp_q);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      en_q    <= '0;
      cmp_q   <= '0;
      rd_data <= '0;
      win_rst <= 1'b0;
    end else begin
      win_rst <= ctrl_wr && !ctrl_q[CTRL_WIN_BIT] && wr_data[CTRL_WIN_BIT];
      if (ctrl_wr) ctrl_q <= wr_data;
      if (stat_wr) en_q <= en_new;
      if (cmp_wr && (wr_data[LINE_W-1:0] != cmp_q)) cmp_q <= wr_data[LINE_W-1:0];
      if (rd_en) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/lcdstat_srcs.sv
module lcdstat_srcs
  import lcdstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            disp,
  input  logic [1:0]      mode_in,
  input  logic            stat_wr,
  input  logic [NSRC-1:0] en_new,
  input  logic [NSRC-1:0] en_q,
  input  logic            match_now,
  output logic            irq
);
  logic [1:0]           mode_q;
  logic [NMODE_SRC-1:0] ms_q, ms_n, base_m, hit;
  logic                 lc_q, lc_n, base_c, search_pend, fire;
  logic [NSRC-1:0]      en_eff;

  assign en_eff = stat_wr ? en_new : en_q;
  assign base_m = stat_wr ? (ms_q & en_new[NMODE_SRC-1:0]) : ms_q;
  assign base_c = stat_wr ? (lc_q & en_new[SRC_COIN]) : lc_q;

  for (genvar i = 0; i < NMODE_SRC; i++) begin : g_hit
    assign hit[i] = en_eff[i] && (mode_in == 2'(i));
  end

  always_comb begin
    search_pend = 1'b0;
    if (mode_in != mode_q) begin
      ms_n = hit;
    end else if (stat_wr) begin
      ms_n = base_m | {1'b0, hit[1:0]};
      search_pend = hit[2];
    end else begin
      ms_n = ms_q;
    end
    lc_n = en_eff[SRC_COIN] && match_now;
    fire = (base_m == '0) && !base_c && ((ms_n != '0) || lc_n || search_pend);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      ms_q   <= '0;
      lc_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      mode_q <= mode_in;
      if (!disp) begin
        ms_q <= '0;
        lc_q <= 1'b0;
        irq  <= 1'b0;
      end else begin
        ms_q <= ms_n;
        lc_q <= lc_n;
        irq  <= fire;
      end
    end
  end
endmodule

// File: rtl/lcdstat_irq_ctrl.sv
module lcdstat_irq_ctrl
  import lcdstat_pkg::*;
#(
  parameter int unsigned LINE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        reg_sel,
  input  logic [7:0]        wr_data,
  input  logic [1:0]        mode_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [7:0]        rd_data,
  output logic              irq_pulse,
  output logic              disp_en,
  output logic              win_rst
);
  logic [REG_W-1:0]  ctrl_q;
  logic [NSRC-1:0]   en_q, en_new;
  logic [LINE_W-1:0] cmp_q, cmp_eff;
  logic              stat_wr, match_now;

  lcdstat_regs #(.LINE_W(LINE_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .sel(reg_sel),
    .wr_data(wr_data), .mode_in(mode_in), .line_in(line_in),
    .ctrl_q(ctrl_q), .en_q(en_q), .cmp_q(cmp_q), .cmp_eff(cmp_eff),
    .stat_wr(stat_wr), .en_new(en_new), .rd_data(rd_data), .win_rst(win_rst)
  );

  assign disp_en   = ctrl_q[CTRL_DISP_BIT];
  assign match_now = disp_en && (line_in == cmp_eff);

  lcdstat_srcs u_srcs (
    .clk(clk), .rst(rst), .disp(disp_en), .mode_in(mode_in),
    .stat_wr(stat_wr), .en_new(en_new), .en_q(en_q),
    .match_now(match_now), .irq(irq_pulse)
  );
endmodule

// File: rtl/lcdstat_chk.sv
module lcdstat_chk #(
  parameter int unsigned LINE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [1:0]        reg_sel,
  input logic [7:0]        wr_data,
  input logic [1:0]        mode_in,
  input logic [LINE_W-1:0] line_in,
  input logic [7:0]        rd_data,
  input logic              irq_pulse,
  input logic              disp_en,
  input logic              win_rst,
  input logic [LINE_W-1:0] cmp_q
);
  a_r10_no_irq_when_off: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> !irq_pulse);

  a_r4_win_single: assert property (@(posedge clk) disable iff (rst)
    win_rst |=> !win_rst);

  a_r4_disp_follows: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd0) |=> (disp_en == $past(wr_data[7])));

  a_r2_stat_read_shape: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd1) |=> (rd_data[7] && rd_data[1:0] == $past(mode_in)));

  a_r3_line_off_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd2 && !disp_en) |=> (rd_data == 8'h00));

  a_r5_cmp_store: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 2'd3) |=> (cmp_q == $past(wr_data[LINE_W-1:0])));

  a_r2_line_read_on: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == 2'd2 && disp_en) |=> (rd_data == 8'($past(line_in))));
endmodule

bind lcdstat_irq_ctrl lcdstat_chk #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
  .wr_data(wr_data), .mode_in(mode_in), .line_in(line_in), .rd_data(rd_data),
  .irq_pulse(irq_pulse), .disp_en(disp_en), .win_rst(win_rst), .cmp_q(cmp_q)
);

// File: tb/sim_lcdstat_irq_ctrl.sv
module sim_lcdstat_irq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode_in = '0;
  logic [7:0] line_in = '0;
  logic [7:0] rd_data;
  logic irq_pulse, disp_en, win_rst;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] m_ctrl, m_cmp, m_rd;
  logic [3:0] m_en;
  logic [2:0] m_ms;
  logic       m_lc;
  logic [1:0] m_modeq;
  logic       got_irq;

  always #5 clk = ~clk;

  lcdstat_irq_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_sel(reg_sel),
    .wr_data(wr_data), .mode_in(mode_in), .line_in(line_in),
    .rd_data(rd_data), .irq_pulse(irq_pulse), .disp_en(disp_en), .win_rst(win_rst)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] s, input logic [1:0] md, input logic [7:0] ln);
    logic disp = m_ctrl[7];
    case (s)
      2'd0:    return m_ctrl;
      2'd1:    return {1'b1, m_en, disp && (ln == m_cmp), md};
      2'd2:    return disp ? ln : 8'h00;
      default: return m_cmp;
    endcase
  endfunction

  // one clock: inputs applied at the falling edge, results sampled after the rising edge
  task automatic cyc(input logic we, input logic re, input logic [1:0] s, input logic [7:0] wd,
                     input logic [1:0] md, input logic [7:0] ln);
    logic disp, stw, cmpw, match, lc_n, fire, pend, e_irq, e_win;
    logic [7:0] cmp_e;
    logic [3:0] en_e;
    logic [2:0] bm, hit, ms_n;
    logic bc;
    wr_en = we; rd_en = re; reg_sel = s; wr_data = wd; mode_in = md; line_in = ln;
    disp  = m_ctrl[7];
    stw   = we && s == 2'd1;
    cmpw  = we && s == 2'd3;
    cmp_e = cmpw ? wd : m_cmp;
    match = disp && (ln == cmp_e);
    en_e  = stw ? wd[6:3] : m_en;
    bm    = stw ? (m_ms & wd[5:3]) : m_ms;
    bc    = stw ? (m_lc & wd[6]) : m_lc;
    for (int i = 0; i < 3; i++) hit[i] = en_e[i] && (md == 2'(i));
    pend = 1'b0;
    if (md != m_modeq) ms_n = hit;
    else if (stw) begin ms_n = bm | {1'b0, hit[1:0]}; pend = hit[2]; end
    else ms_n = m_ms;
    lc_n  = en_e[3] && match;
    fire  = (bm == 3'd0) && !bc && ((ms_n != 3'd0) || lc_n || pend);
    e_irq = disp && fire;
    e_win = we && s == 2'd0 && !m_ctrl[5] && wd[5];
    if (re) m_rd = exp_read(s, md, ln);
    @(posedge clk);
    #2;
    got_irq = irq_pulse;
    chk("R6 irq", {7'd0, irq_pulse}, {7'd0, e_irq});
    chk("R4 win_rst", {7'd0, win_rst}, {7'd0, e_win});
    if (re) chk("R2 read", rd_data, m_rd);
    // model update
    if (we && s == 2'd0) m_ctrl = wd;
    if (stw) m_en = wd[6:3];
    if (cmpw) m_cmp = wd;
    if (disp) begin m_ms = ms_n; m_lc = lc_n; end
    else begin m_ms = '0; m_lc = 1'b0; end
    m_modeq = md;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctrl = '0; m_cmp = '0; m_rd = '0; m_en = '0; m_ms = '0; m_lc = 1'b0; m_modeq = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 irq", {7'd0, irq_pulse}, 8'h00);
    chk("R1 disp_en", {7'd0, disp_en}, 8'h00);
    @(negedge clk);
    cyc(0, 1, 2'd1, 8'h00, 2'd2, 8'd4);      // R1/R2 status read = 0x82
    chk("R1 status", rd_data, 8'h82);
    cyc(0, 1, 2'd0, 8'h00, 2'd2, 8'd4);
    chk("R1 ctrl", rd_data, 8'h00);
    // R10: display off, enable hblank in mode 0 -> nothing
    cyc(1, 0, 2'd1, 8'h08, 2'd0, 8'd4);
    chk("R10 off no irq", {7'd0, got_irq}, 8'h00);
    cyc(0, 1, 2'd2, 8'h00, 2'd0, 8'd4);
    chk("R3 line off", rd_data, 8'h00);
    // R4 display on with window bit rising
    cyc(1, 0, 2'd0, 8'hA0, 2'd0, 8'd4);
    chk("R4 win pulse", {7'd0, win_rst}, 8'h01);
    chk("R4 disp_en", {7'd0, disp_en}, 8'h01);
    cyc(0, 1, 2'd2, 8'h00, 2'd0, 8'd4);
    chk("R3 line on", rd_data, 8'h04);
    // R7: mode change 0->1->0 with hblank enabled
    cyc(0, 0, 2'd0, 8'h00, 2'd1, 8'd4);
    cyc(0, 0, 2'd0, 8'h00, 2'd0, 8'd4);
    chk("R7 mode recompute irq", {7'd0, got_irq}, 8'h01);
    cyc(0, 0, 2'd0, 8'h00, 2'd0, 8'd4);
    chk("R6 single pulse", {7'd0, got_irq}, 8'h00);
    // R8: disable all then re-enable hblank in mode 0 -> immediate
    cyc(1, 0, 2'd1, 8'h00, 2'd0, 8'd4);
    cyc(1, 0, 2'd1, 8'hF8, 2'd0, 8'd4);      // also writes bit7 ignored
    chk("R8 status write irq", {7'd0, got_irq}, 8'h01);
    cyc(0, 1, 2'd1, 8'h00, 2'd0, 8'd4);
    chk("R2 status mask", rd_data, 8'hF8);
    // R9: search quirk, then coincidence still fires
    cyc(1, 0, 2'd1, 8'h00, 2'd2, 8'd5);
    cyc(1, 0, 2'd1, 8'h60, 2'd2, 8'd5);
    chk("R9 search write irq", {7'd0, got_irq}, 8'h01);
    cyc(1, 0, 2'd3, 8'd5, 2'd2, 8'd5);
    chk("R9 unlatched then R5 match irq", {7'd0, got_irq}, 8'h01);
    // R5: rewrite same compare value -> no request
    cyc(1, 0, 2'd3, 8'd5, 2'd2, 8'd5);
    chk("R5 same value", {7'd0, got_irq}, 8'h00);
    // R11: mismatch then rematch
    cyc(1, 0, 2'd1, 8'h40, 2'd3, 8'd6);
    cyc(0, 0, 2'd0, 8'h00, 2'd3, 8'd5);
    chk("R11 rematch irq", {7'd0, got_irq}, 8'h01);
    // random phase
    begin
      logic [1:0] md;
      md = 2'd3;
      for (int n = 0; n < 4000; n++) begin
        logic [1:0] s;
        logic [7:0] wd;
        logic we, re;
        if ($urandom_range(0, 3) == 0) md = 2'($urandom);
        s  = 2'($urandom);
        we = ($urandom_range(0, 3) == 0);
        re = ($urandom_range(0, 2) == 0);
        wd = 8'($urandom);
        if (s == 2'd0 && $urandom_range(0, 3) != 0) wd[7] = 1'b1;
        if (s == 2'd3) wd = 8'($urandom_range(0, 7));
        if (s == 2'd2) we = 1'b0;
        cyc(we, re, s, wd, md, 8'($urandom_range(0, 7)));
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule